// File: doc/BRIEF.md
# CAN FD Dual-Rate Bit Timing Generator

This block produces the bit timing for a CAN FD protocol controller. It holds two timing settings, one for the nominal (arbitration) rate and one for the faster data rate. Each setting is a prescaler plus two segment lengths. A bit is a one-quantum synchronisation segment, then segment 1, then segment 2. The block raises a one-cycle sample strobe on the last clock of segment 1 and a one-cycle bit-end strobe on the last clock of segment 2.

The protocol engine tells the block where it is in the frame:
- a start-of-frame pulse;
- whether the frame is FD;
- a marker that is high for the whole bit-rate-switch bit, together with that bit's value;
- a marker that is high for the whole CRC delimiter bit.

The block changes to the data setting at the sample strobe of the switch bit. The three conditions are that the frame is FD, the switch bit is recessive, and the switch enable was 1 when the frame started. It changes back to the nominal setting at the sample strobe of the CRC delimiter. The start-of-frame pulse also restarts the bit at its synchronisation segment.

Top module: `canfd_dual_bittime`

## Requirements
- R1: During reset, `sample_o`, `bit_end_o` and `data_rate_o` are 0. Count the first clock edge with `rst_n` high as edge 1. The first sample strobe is then high in the cycle after edge Pn·(1+S1n)−1. A prescaler value is the number of clocks per quantum (at least 1). A segment value is its length in quanta (at least 1).
- R2: At the nominal setting, successive sample strobes are Pn·(1+S1n+S2n) cycles apart. `bit_end_o` pulses Pn·S2n cycles after each sample strobe.
- R3: A `sof_i` pulse restarts the bit at its synchronisation segment. `sample_o` and `bit_end_o` are low in the cycle after the edge that captures `sof_i`. The first sample strobe comes P·(1+S1)−1 edges after that edge.
- R4: `rate_sw_en_i` is captured only at `sof_i`. Changing it during a frame has no effect on that frame.
- R5: The data setting is selected at the sample strobe of a bit with `brs_bit_i`=1, when `fd_frame_i`=1, `brs_val_i`=1 and the captured enable is 1. `data_rate_o` rises in the next cycle, and the rest of that bit lasts Pd·S2d cycles.
- R6: While `data_rate_o` is 1, each bit uses the data setting. The spacing from a bit end to the next sample strobe is Pd·(1+S1d).
- R7: At the sample strobe of a bit with `crc_delim_i`=1, the block returns to the nominal setting. The rest of that bit lasts Pn·S2n cycles.
- R8: A switch bit of value 0 (`brs_val_i`=0) keeps the nominal setting for the whole frame.
- R9: A frame with `fd_frame_i`=0 never selects the data setting, whatever the enable and switch-bit value are.
- R10: `sof_i` forces the nominal setting, even when it arrives during the data phase.
- R11: Each bit carries exactly one sample strobe. The sample strobe and the bit-end strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nom_presc_i | input | 8 | Nominal clocks per quantum |
| nom_seg1_i | input | 7 | Nominal segment 1 length in quanta |
| nom_seg2_i | input | 5 | Nominal segment 2 length in quanta |
| dat_presc_i | input | 8 | Data-rate clocks per quantum |
| dat_seg1_i | input | 7 | Data-rate segment 1 length in quanta |
| dat_seg2_i | input | 5 | Data-rate segment 2 length in quanta |
| rate_sw_en_i | input | 1 | Rate-switch enable, captured at start of frame |
| fd_frame_i | input | 1 | Current frame is in FD format |
| brs_bit_i | input | 1 | Current bit is the rate-switch bit |
| brs_val_i | input | 1 | Value of the rate-switch bit (1 = recessive) |
| crc_delim_i | input | 1 | Current bit is the CRC delimiter |
| sof_i | input | 1 | Start-of-frame pulse; restarts the bit |
| sample_o | output | 1 | Sample-point strobe |
| bit_end_o | output | 1 | Last-cycle-of-bit strobe |
| data_rate_o | output | 1 | 1 while the data setting is active |

## Verification
The bench measures the cycle distances from each bit end to the next sample strobe, and from each sample strobe to the following bit end, across the whole frame. It does this for every combination of FD flag, switch-bit value and enable, and over a sweep of timing settings.

The switch bit is the sharpest case:
- A design that switched at the bit boundary instead of at the sample point would give that bit a nominal segment 2, so its tail would be the wrong length.
- A design that switched one bit late would give the first data bit a nominal segment 1.

The CRC delimiter is checked the same way in the other direction. The enable is flipped right after every start of frame, so a design that reads it live is caught. A frame cut short in its data phase checks that the next start of frame restores the nominal setting.

// File: rtl/can_fdbt_pkg.sv
// Shared widths and types for the dual-rate bit timing block.
// Assumes: segment and prescaler values fit the widths below.
package can_fdbt_pkg;
    localparam int PRESC_W = 8;
    localparam int SEG1_W  = 7;
    localparam int SEG2_W  = 5;
    localparam int SEGC_W  = (SEG1_W > SEG2_W) ? SEG1_W : SEG2_W;

    // one rate setting: clocks per quantum and two segment lengths in quanta
    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [SEG1_W-1:0]  seg1;
        logic [SEG2_W-1:0]  seg2;
    } bit_cfg_t;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_SEG1 = 2'd1,
        PH_SEG2 = 2'd2
    } bit_phase_e;
endpackage

// File: rtl/fdbt_tq_gen.sv
// Quantum tick generator: tq_end_o is high on the last clock of each quantum.
// Assumes: presc_i >= 1; presc_i only changes at a quantum boundary or in reset.
module fdbt_tq_gen
    import can_fdbt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart_i,
    input  logic [PRESC_W-1:0] presc_i,
    output logic               tq_end_o
);
    localparam logic [PRESC_W-1:0] ONE = PRESC_W'(1);

    logic [PRESC_W-1:0] clk_cnt;

    assign tq_end_o = (clk_cnt == (presc_i - ONE));

    // count clocks inside the current quantum, wrapping at its end
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            clk_cnt <= '0;
        end else if (tq_end_o) begin
            clk_cnt <= '0;
        end else begin
            clk_cnt <= clk_cnt + ONE;
        end
    end

    assert_tq_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_i != '0) |-> (clk_cnt < presc_i));
endmodule

// File: rtl/fdbt_phase.sv
// Bit phase sequencer: SYNC (1 tq), segment 1, segment 2. Raises the sample strobe
// on the last clock of segment 1 and the bit-end strobe on the last clock of segment 2.
// Assumes: seg1_i >= 1 and seg2_i >= 1; tq_end_i comes from the quantum generator.
module fdbt_phase
    import can_fdbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              tq_end_i,
    input  logic [SEG1_W-1:0] seg1_i,
    input  logic [SEG2_W-1:0] seg2_i,
    output logic              sample_o,
    output logic              bit_end_o
);
    localparam logic [SEGC_W-1:0] ONE = SEGC_W'(1);

    bit_phase_e        phase;
    logic [SEGC_W-1:0] seg_cnt;
    logic              seg1_last;
    logic              seg2_last;

    // last quantum of each segment, compared in the common counter width
    always_comb begin
        seg1_last = (seg_cnt == (SEGC_W'(seg1_i) - ONE));
        seg2_last = (seg_cnt == (SEGC_W'(seg2_i) - ONE));
    end

    assign sample_o  = tq_end_i && (phase == PH_SEG1) && seg1_last;
    assign bit_end_o = tq_end_i && (phase == PH_SEG2) && seg2_last;

    // step through the segments one quantum at a time
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            phase   <= PH_SYNC;
            seg_cnt <= '0;
        end else if (tq_end_i) begin
            unique case (phase)
                PH_SYNC: begin
                    phase   <= PH_SEG1;
                    seg_cnt <= '0;
                end
                PH_SEG1: begin
                    if (seg1_last) begin
                        phase   <= PH_SEG2;
                        seg_cnt <= '0;
                    end else begin
                        seg_cnt <= seg_cnt + ONE;
                    end
                end
                PH_SEG2: begin
                    if (seg2_last) begin
                        phase   <= PH_SYNC;
                        seg_cnt <= '0;
                    end else begin
                        seg_cnt <= seg_cnt + ONE;
                    end
                end
                default: begin
                    phase   <= PH_SYNC;
                    seg_cnt <= '0;
                end
            endcase
        end
    end

    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_o && bit_end_o));
    assert_restart_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!sample_o && !bit_end_o));
endmodule

// File: rtl/fdbt_rate_ctrl.sv
// Rate selector: captures the switch enable at start of frame, selects the data
// rate at the sample point of a qualifying switch bit, and returns to nominal at
// the sample point of the CRC delimiter or at the next start of frame.
// Assumes: phase markers are held for the whole bit they mark.
module fdbt_rate_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic sof_i,
    input  logic switch_en_i,
    input  logic fdf_i,
    input  logic brs_bit_i,
    input  logic brs_val_i,
    input  logic crc_delim_i,
    input  logic sample_i,
    output logic data_rate_o
);
    logic en_frame;
    logic go_data;
    logic go_nominal;

    // switch and return conditions, both evaluated at the sample point
    always_comb begin
        go_data    = sample_i && !data_rate_o && brs_bit_i && fdf_i && brs_val_i && en_frame;
        go_nominal = sample_i && data_rate_o && crc_delim_i;
    end

    // hold the enable seen at start of frame for the whole frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_frame <= 1'b0;
        end else if (sof_i) begin
            en_frame <= switch_en_i;
        end
    end

    // track the active rate
    always_ff @(posedge clk) begin
        if (!rst_n || sof_i) begin
            data_rate_o <= 1'b0;
        end else if (go_nominal) begin
            data_rate_o <= 1'b0;
        end else if (go_data) begin
            data_rate_o <= 1'b1;
        end
    end

    assert_rise_at_brs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_rate_o) |-> $past(sample_i && brs_bit_i && !sof_i));
    assert_rise_recessive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_rate_o) |-> $past(brs_val_i));
    assert_rise_fd_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_rate_o) |-> $past(fdf_i));
    assert_fall_point_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_rate_o) |-> $past(sof_i || (sample_i && crc_delim_i)));
    assert_sof_nominal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> !data_rate_o);
endmodule

// File: rtl/canfd_dual_bittime.sv
// Dual-rate CAN FD bit timing generator. Selects the nominal or data setting
// from the rate selector and drives the quantum generator and phase sequencer.
// Assumes: settings are static outside reset; both settings use the same
// quantum length when a frame must keep one quantum throughout.
module canfd_dual_bittime
    import can_fdbt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] nom_presc_i,
    input  logic [SEG1_W-1:0]  nom_seg1_i,
    input  logic [SEG2_W-1:0]  nom_seg2_i,
    input  logic [PRESC_W-1:0] dat_presc_i,
    input  logic [SEG1_W-1:0]  dat_seg1_i,
    input  logic [SEG2_W-1:0]  dat_seg2_i,
    input  logic               rate_sw_en_i,
    input  logic               fd_frame_i,
    input  logic               brs_bit_i,
    input  logic               brs_val_i,
    input  logic               crc_delim_i,
    input  logic               sof_i,
    output logic               sample_o,
    output logic               bit_end_o,
    output logic               data_rate_o
);
    bit_cfg_t nom_cfg;
    bit_cfg_t dat_cfg;
    bit_cfg_t act_cfg;
    logic     tq_end;

    // pick the setting for the current rate
    always_comb begin
        nom_cfg = '{presc: nom_presc_i, seg1: nom_seg1_i, seg2: nom_seg2_i};
        dat_cfg = '{presc: dat_presc_i, seg1: dat_seg1_i, seg2: dat_seg2_i};
        act_cfg = data_rate_o ? dat_cfg : nom_cfg;
    end

    fdbt_tq_gen u_tq (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (sof_i),
        .presc_i   (act_cfg.presc),
        .tq_end_o  (tq_end)
    );

    fdbt_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (sof_i),
        .tq_end_i  (tq_end),
        .seg1_i    (act_cfg.seg1),
        .seg2_i    (act_cfg.seg2),
        .sample_o  (sample_o),
        .bit_end_o (bit_end_o)
    );

    fdbt_rate_ctrl u_rate (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_i       (sof_i),
        .switch_en_i (rate_sw_en_i),
        .fdf_i       (fd_frame_i),
        .brs_bit_i   (brs_bit_i),
        .brs_val_i   (brs_val_i),
        .crc_delim_i (crc_delim_i),
        .sample_i    (sample_o),
        .data_rate_o (data_rate_o)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!data_rate_o));
endmodule

// File: tb/canfd_dual_bittime_bench.sv
module canfd_dual_bittime_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] nom_presc_i = 8'd1;
    logic [6:0] nom_seg1_i = 7'd1;
    logic [4:0] nom_seg2_i = 5'd1;
    logic [7:0] dat_presc_i = 8'd1;
    logic [6:0] dat_seg1_i = 7'd1;
    logic [4:0] dat_seg2_i = 5'd1;
    logic       rate_sw_en_i = 1'b0;
    logic       fd_frame_i = 1'b0;
    logic       brs_bit_i = 1'b0;
    logic       brs_val_i = 1'b0;
    logic       crc_delim_i = 1'b0;
    logic       sof_i = 1'b0;
    logic       sample_o;
    logic       bit_end_o;
    logic       data_rate_o;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    int pn, s1n, s2n, pd, s1d, s2d;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    canfd_dual_bittime u_canfd_dual_bittime (
        .clk(clk), .rst_n(rst_n),
        .nom_presc_i(nom_presc_i), .nom_seg1_i(nom_seg1_i), .nom_seg2_i(nom_seg2_i),
        .dat_presc_i(dat_presc_i), .dat_seg1_i(dat_seg1_i), .dat_seg2_i(dat_seg2_i),
        .rate_sw_en_i(rate_sw_en_i), .fd_frame_i(fd_frame_i), .brs_bit_i(brs_bit_i),
        .brs_val_i(brs_val_i), .crc_delim_i(crc_delim_i), .sof_i(sof_i),
        .sample_o(sample_o), .bit_end_o(bit_end_o), .data_rate_o(data_rate_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual %0d expected %0d (cfg %0d/%0d/%0d %0d/%0d/%0d)",
                     req, act, exp, pn, s1n, s2n, pd, s1d, s2d);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    // R1: reset state and first sample strobe
    task automatic do_reset();
        int c0;
        int guard;
        @(negedge clk);
        rst_n = 1'b0;
        nom_presc_i = 8'(pn); nom_seg1_i = 7'(s1n); nom_seg2_i = 5'(s2n);
        dat_presc_i = 8'(pd); dat_seg1_i = 7'(s1d); dat_seg2_i = 5'(s2d);
        sof_i = 1'b0; brs_bit_i = 1'b0; crc_delim_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 sample in reset", int'(sample_o), 0);
        check("R1 bit_end in reset", int'(bit_end_o), 0);
        check("R1 data_rate in reset", int'(data_rate_o), 0);
        rst_n = 1'b1;
        c0 = cyc;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!sample_o && guard < 2000);
        check("R1 first sample after reset", cyc - c0, pn * (1 + s1n) - 1);
    endtask

    // one frame of nbits bits; switch bit is bit 3, CRC delimiter is bit 7
    task automatic run_frame(input bit fdf, input bit brs, input bit en, input int nbits);
        int  c0;
        int  last_end;
        int  samp;
        int  bidx;
        int  guard;
        bit  got_sample;
        bit  sw;
        bit  pre_d;
        bit  post_d;
        sw = fdf && brs && en;
        @(negedge clk);
        rate_sw_en_i = en; fd_frame_i = fdf; brs_val_i = brs;
        brs_bit_i = 1'b0; crc_delim_i = 1'b0; sof_i = 1'b1;
        @(negedge clk);
        sof_i = 1'b0;
        c0 = cyc;
        rate_sw_en_i = !en;   // R4: mid-frame change must be ignored
        check("R10 data_rate after sof", int'(data_rate_o), 0);
        check("R3 sample after sof", int'(sample_o), 0);
        check("R3 bit_end after sof", int'(bit_end_o), 0);
        last_end = c0; samp = c0; bidx = 0; got_sample = 1'b0; guard = 0;
        while (bidx < nbits && guard < 20000) begin
            brs_bit_i   = (bidx == 3);
            crc_delim_i = (bidx == 7);
            @(negedge clk);
            guard++;
            pre_d  = sw && bidx >= 4 && bidx <= 7;
            post_d = sw && bidx >= 3 && bidx <= 6;
            if (sample_o) begin
                if (bidx == 0)
                    check("R3 first sample after sof", cyc - last_end, pn * (1 + s1n) - 1);
                else if (pre_d)
                    check("R6 data bit end to sample", cyc - last_end, pd * (1 + s1d));
                else
                    check("R2 nominal bit end to sample", cyc - last_end, pn * (1 + s1n));
                check("R11 single sample per bit", int'(got_sample), 0);
                check("R11 sample with bit_end", int'(bit_end_o), 0);
                got_sample = 1'b1;
                samp = cyc;
            end
            if (bit_end_o) begin
                check("R11 sample seen in bit", int'(got_sample), 1);
                if (bidx == 3 && sw)
                    check("R5 switch bit tail", cyc - samp, pd * s2d);
                else if (bidx == 7 && sw)
                    check("R7 delimiter tail", cyc - samp, pn * s2n);
                else if (post_d)
                    check("R6 data bit tail", cyc - samp, pd * s2d);
                else if (!fdf)
                    check("R9 classic tail", cyc - samp, pn * s2n);
                else if (!brs)
                    check("R8 dominant switch bit tail", cyc - samp, pn * s2n);
                else if (!en)
                    check("R4 latched enable tail", cyc - samp, pn * s2n);
                else
                    check("R2 nominal tail", cyc - samp, pn * s2n);
                check("R5 R7 data_rate level", int'(data_rate_o), int'(post_d));
                last_end = cyc;
                got_sample = 1'b0;
                bidx++;
            end
        end
        check("R2 frame completed", bidx, nbits);
        brs_bit_i = 1'b0;
        crc_delim_i = 1'b0;
    endtask

    initial begin
        #(4 * 190000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
                for (int c = 0; c < 2; c++) begin
                    for (int d = 0; d < 2; d++) begin
                        for (int e = 0; e < 2; e++) begin
                            pn  = a ? 3 : 1;
                            s1n = b ? 5 : 2;
                            s2n = c ? 2 : 1;
                            pd  = d ? 2 : 1;
                            s1d = e ? 3 : 1;
                            s2d = e ? 2 : 1;
                            do_reset();
                            for (int f = 0; f < 8; f++) begin
                                run_frame(f[2], f[1], f[0], 10);
                            end
                            // R10: frame cut short inside the data phase
                            run_frame(1'b1, 1'b1, 1'b1, 5);
                            run_frame(1'b1, 1'b1, 1'b1, 10);
                        end
                    end
                end
            end
        end
        finish_run();
    end
endmodule